// File: doc/BRIEF.md
# Paired-Way Duplicate Read Recovery Store

This block holds the data of the low-voltage ways of a cache set and guards clean lines without any correction code. The ways are tied into fixed couples, and the partner of a way is the way whose index differs only in bit 0. A write hit lands in the addressed way and, one cycle later, in its partner. Each stored line carries one even-parity bit per byte.

A read checks the parity of the addressed way. If the line is good it is returned as is. If it is bad, and the partner is marked as holding a mirror that is itself good, the partner's copy is returned. Otherwise the block asks the next level for the line and holds the response. The returned data is written into both ways with fresh parity and then handed back. Tag lookup, replacement and the next level sit outside. A fault-injection port flips stored bits so that weak cells can be modelled.

Requests use a two-bit opcode: 0 read, 1 write hit, 2 fill (installing a line after a read miss), 3 evict.

Top module: `dupway_store`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and fetch_req_valid is 0.
- R2: A write (op 1) to way w of a set stores its data in way w and in the partner way w^1 (0 with 1, 2 with 3), so a read of either way returns it.
- R3: A write takes two cycles: req_ready is 0 in the cycle after the write is accepted and is 1 again in the cycle after that.
- R4: A read (op 0) of a line with correct parity raises rsp_valid in the cycle after acceptance, with status 0 and the stored data.
- R5: Parity is one even bit per byte (bits 8k+7..8k). A single flipped bit in any byte marks the whole line as erroneous.
- R6: When the addressed way is erroneous, its duplicate flag is set and the partner is correct, the response comes in the cycle after acceptance with the partner's data and status 1.
- R7: A fill (op 2) writes only the addressed way and clears the duplicate flag of both ways of the couple, so a later error in either way is not served from the partner.
- R8: An evict (op 3) clears the duplicate flag of both ways of the couple and leaves the stored data unchanged.
- R9: When no good copy exists, fetch_req_valid rises in the cycle after acceptance and holds the read's set and way until fetch_rsp_valid. The response, with status 2 and the fetched data, comes in the cycle after fetch_rsp_valid.
- R10: Refetched data is written into both ways with fresh parity and the duplicate flag set. Later reads of either way return it with status 0, and a later error in one way is served from the other.
- R11: A read whose addressed way and partner are both erroneous goes to refetch even when the duplicate flag is set.
- R12: rsp_status never takes the value 3.
- R13: A request presented while req_ready is 0 is ignored and changes no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_op | input | 2 | 0 read, 1 write hit, 2 fill, 3 evict |
| req_set | input | SET_W | Set index |
| req_way | input | WAY_W | Way index |
| req_data | input | DATA_W | Write or fill data |
| rsp_valid | output | 1 | Read response present (one cycle) |
| rsp_status | output | 2 | 0 clean, 1 from partner, 2 after refetch |
| rsp_data | output | DATA_W | Read data |
| fetch_req_valid | output | 1 | Refetch request to the next level |
| fetch_req_set | output | SET_W | Set of the line to refetch |
| fetch_req_way | output | WAY_W | Way of the line to refetch |
| fetch_rsp_valid | input | 1 | Refetched data present |
| fetch_rsp_data | input | DATA_W | Refetched data |
| inj_valid | input | 1 | Flip stored bits this cycle |
| inj_set | input | SET_W | Set to corrupt |
| inj_way | input | WAY_W | Way to corrupt |
| inj_mask | input | DATA_W | Bits to flip in the stored data |

## Verification
A read that is served from the array, whether from the addressed way or its partner, is due one cycle after the edge that accepts it. A refetch request appears one cycle after acceptance, and its response is due exactly one cycle after the edge that samples fetch_rsp_valid. The write's busy cycle is due one cycle after acceptance. The bench drives on the falling edge and checks each of these on the falling edge at its due time. It checks the refetch timings against recorded times of issue and of data return, so that a response one cycle early or late fails.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_FILL  = 2'd2,
        OP_EVICT = 2'd3
    } dws_op_e;

    typedef enum logic [1:0] {
        ST_CLEAN   = 2'd0,
        ST_PARTNER = 2'd1,
        ST_REFETCH = 2'd2
    } dws_status_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_MIRROR  = 2'd1,
        S_REFETCH = 2'd2
    } dws_state_e;

endpackage

// File: rtl/dws_parity.sv
`timescale 1ns/1ps
module dws_parity
    import dws_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int PAR_W = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] data,
    output logic [PAR_W-1:0]  par
);
    // one even-parity bit per byte lane
    for (genvar g = 0; g < PAR_W; g++) begin : g_lane
        assign par[g] = ^data[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/dws_chk.sv
`timescale 1ns/1ps
module dws_chk
    import dws_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int PAR_W = DATA_W / BYTE_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic [PAR_W-1:0]  par,
    output logic              err
);
    logic [PAR_W-1:0] recomputed;

    dws_parity #(.DATA_W(DATA_W)) u_regen (
        .data (data),
        .par  (recomputed)
    );

    // any lane mismatch poisons the whole line
    assign err = |(recomputed ^ par);
endmodule

// File: rtl/dws_array.sv
`timescale 1ns/1ps
module dws_array
    import dws_pkg::*;
#(
    parameter int NSETS  = 4,
    parameter int NWAYS  = 4,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(NSETS),
    localparam int WAY_W = $clog2(NWAYS),
    localparam int PAR_W = DATA_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_pair,
    input  logic [SET_W-1:0]  op_set,
    input  logic [WAY_W-1:0]  op_way,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAR_W-1:0]  wr_par,
    input  logic              dup_clr,
    input  logic              dup_mark,
    input  logic              inj_en,
    input  logic [SET_W-1:0]  inj_set,
    input  logic [WAY_W-1:0]  inj_way,
    input  logic [DATA_W-1:0] inj_mask,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [DATA_W-1:0] rd_data,
    output logic [PAR_W-1:0]  rd_par,
    output logic              rd_dup,
    output logic [DATA_W-1:0] pt_data,
    output logic [PAR_W-1:0]  pt_par
);
    logic [DATA_W-1:0] data_q [NSETS][NWAYS];
    logic [PAR_W-1:0]  par_q  [NSETS][NWAYS];
    logic              dup_q  [NSETS][NWAYS];

    logic [WAY_W-1:0] rd_pt_way;
    logic [WAY_W-1:0] op_pt_way;
    assign rd_pt_way = rd_way ^ WAY_W'(1);
    assign op_pt_way = op_way ^ WAY_W'(1);

    // data and parity storage; a write beats an injection on the same line
    always_ff @(posedge clk) begin
        for (int s = 0; s < NSETS; s++) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (wr_en && op_set == SET_W'(s) &&
                    (op_way == WAY_W'(w) || (wr_pair && op_pt_way == WAY_W'(w)))) begin
                    data_q[s][w] <= wr_data;
                    par_q[s][w]  <= wr_par;
                end else if (inj_en && inj_set == SET_W'(s) && inj_way == WAY_W'(w)) begin
                    data_q[s][w] <= data_q[s][w] ^ inj_mask;
                end
            end
        end
    end

    // duplicate flags move together for both ways of a couple
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                for (int w = 0; w < NWAYS; w++) begin
                    dup_q[s][w] <= 1'b0;
                end
            end
        end else begin
            for (int s = 0; s < NSETS; s++) begin
                for (int w = 0; w < NWAYS; w++) begin
                    if ((dup_clr || dup_mark) && op_set == SET_W'(s) &&
                        (op_way | WAY_W'(1)) == (WAY_W'(w) | WAY_W'(1))) begin
                        dup_q[s][w] <= dup_mark;
                    end
                end
            end
        end
    end

    assign rd_data = data_q[rd_set][rd_way];
    assign rd_par  = par_q[rd_set][rd_way];
    assign rd_dup  = dup_q[rd_set][rd_way];
    assign pt_data = data_q[rd_set][rd_pt_way];
    assign pt_par  = par_q[rd_set][rd_pt_way];
endmodule

// File: rtl/dws_ctrl.sv
`timescale 1ns/1ps
module dws_ctrl
    import dws_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SET_W  = 2,
    parameter int WAY_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [SET_W-1:0]  req_set,
    input  logic [WAY_W-1:0]  req_way,
    input  logic [DATA_W-1:0] req_data,
    input  logic              sel_err,
    input  logic              pt_err,
    input  logic              rd_dup,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pt_data,
    output logic [SET_W-1:0]  rd_set,
    output logic [WAY_W-1:0]  rd_way,
    output logic              wr_en,
    output logic              wr_pair,
    output logic [SET_W-1:0]  op_set,
    output logic [WAY_W-1:0]  op_way,
    output logic [DATA_W-1:0] wr_data,
    output logic              dup_clr,
    output logic              dup_mark,
    output logic              fetch_req_valid,
    output logic [SET_W-1:0]  fetch_req_set,
    output logic [WAY_W-1:0]  fetch_req_way,
    input  logic              fetch_rsp_valid,
    input  logic [DATA_W-1:0] fetch_rsp_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_data
);
    dws_state_e        state_q;
    logic [SET_W-1:0]  set_q;
    logic [WAY_W-1:0]  way_q;
    logic [DATA_W-1:0] line_q;
    logic              rsp_valid_q;
    dws_status_e       rsp_status_q;
    logic [DATA_W-1:0] rsp_data_q;

    dws_op_e op;
    logic    idle;
    assign op        = dws_op_e'(req_op);
    assign idle      = (state_q == S_IDLE);
    assign req_ready = idle;

    assign rd_set = idle ? req_set : set_q;
    assign rd_way = idle ? req_way : way_q;

    assign fetch_req_valid = (state_q == S_REFETCH);
    assign fetch_req_set   = set_q;
    assign fetch_req_way   = way_q;

    always_comb begin
        wr_en    = 1'b0;
        wr_pair  = 1'b0;
        dup_clr  = 1'b0;
        dup_mark = 1'b0;
        op_set   = rd_set;
        op_way   = rd_way;
        wr_data  = req_data;
        case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    case (op)
                        OP_WRITE: wr_en = 1'b1;
                        OP_FILL: begin
                            wr_en   = 1'b1;
                            dup_clr = 1'b1;
                        end
                        OP_EVICT: dup_clr = 1'b1;
                        default: ;
                    endcase
                end
            end
            S_MIRROR: begin
                wr_en    = 1'b1;
                op_way   = way_q ^ WAY_W'(1);
                wr_data  = line_q;
                dup_mark = 1'b1;
            end
            S_REFETCH: begin
                if (fetch_rsp_valid) begin
                    wr_en    = 1'b1;
                    wr_pair  = 1'b1;
                    wr_data  = fetch_rsp_data;
                    dup_mark = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            set_q        <= '0;
            way_q        <= '0;
            line_q       <= '0;
            rsp_valid_q  <= 1'b0;
            rsp_status_q <= ST_CLEAN;
            rsp_data_q   <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        case (op)
                            OP_READ: begin
                                if (!sel_err) begin
                                    rsp_valid_q  <= 1'b1;
                                    rsp_status_q <= ST_CLEAN;
                                    rsp_data_q   <= rd_data;
                                end else if (rd_dup && !pt_err) begin
                                    rsp_valid_q  <= 1'b1;
                                    rsp_status_q <= ST_PARTNER;
                                    rsp_data_q   <= pt_data;
                                end else begin
                                    state_q <= S_REFETCH;
                                    set_q   <= req_set;
                                    way_q   <= req_way;
                                end
                            end
                            OP_WRITE: begin
                                state_q <= S_MIRROR;
                                set_q   <= req_set;
                                way_q   <= req_way;
                                line_q  <= req_data;
                            end
                            default: ;
                        endcase
                    end
                end
                S_MIRROR: state_q <= S_IDLE;
                S_REFETCH: begin
                    if (fetch_rsp_valid) begin
                        rsp_valid_q  <= 1'b1;
                        rsp_status_q <= ST_REFETCH;
                        rsp_data_q   <= fetch_rsp_data;
                        state_q      <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_status = rsp_status_q;
    assign rsp_data   = rsp_data_q;

    // R3: mirror cycle blocks exactly one cycle
    assert_write_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op == OP_WRITE) |=> !req_ready);
    assert_mirror_single_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_MIRROR) |=> req_ready);
    // R9: refetch address held until data returns
    assert_fetch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (fetch_req_valid && !fetch_rsp_valid) |=>
            (fetch_req_valid && $stable(fetch_req_set) && $stable(fetch_req_way)));
    assert_refetch_after_data_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == ST_REFETCH) |-> $past(fetch_rsp_valid && fetch_req_valid));
    // R4: every response has a cause one cycle earlier
    assert_rsp_cause_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready && req_op == OP_READ) ||
                       $past(fetch_rsp_valid && fetch_req_valid)));
    // R12: no code 3
    assert_status_legal_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 2'd3));
endmodule

// File: rtl/dupway_store.sv
`timescale 1ns/1ps
module dupway_store
    import dws_pkg::*;
#(
    parameter int NSETS  = 4,
    parameter int NWAYS  = 4,
    parameter int DATA_W = 32,
    localparam int SET_W = $clog2(NSETS),
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [SET_W-1:0]  req_set,
    input  logic [WAY_W-1:0]  req_way,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fetch_req_valid,
    output logic [SET_W-1:0]  fetch_req_set,
    output logic [WAY_W-1:0]  fetch_req_way,
    input  logic              fetch_rsp_valid,
    input  logic [DATA_W-1:0] fetch_rsp_data,
    input  logic              inj_valid,
    input  logic [SET_W-1:0]  inj_set,
    input  logic [WAY_W-1:0]  inj_way,
    input  logic [DATA_W-1:0] inj_mask
);
    localparam int PAR_W = DATA_W / BYTE_W;

    logic              wr_en, wr_pair, dup_clr, dup_mark;
    logic [SET_W-1:0]  op_set, rd_set;
    logic [WAY_W-1:0]  op_way, rd_way;
    logic [DATA_W-1:0] wr_data, rd_data, pt_data;
    logic [PAR_W-1:0]  wr_par, rd_par, pt_par;
    logic              rd_dup, sel_err, pt_err;

    dws_parity #(.DATA_W(DATA_W)) u_gen (
        .data (wr_data),
        .par  (wr_par)
    );

    dws_chk #(.DATA_W(DATA_W)) u_sel_chk (
        .data (rd_data),
        .par  (rd_par),
        .err  (sel_err)
    );

    dws_chk #(.DATA_W(DATA_W)) u_pt_chk (
        .data (pt_data),
        .par  (pt_par),
        .err  (pt_err)
    );

    dws_array #(.NSETS(NSETS), .NWAYS(NWAYS), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_pair  (wr_pair),
        .op_set   (op_set),
        .op_way   (op_way),
        .wr_data  (wr_data),
        .wr_par   (wr_par),
        .dup_clr  (dup_clr),
        .dup_mark (dup_mark),
        .inj_en   (inj_valid),
        .inj_set  (inj_set),
        .inj_way  (inj_way),
        .inj_mask (inj_mask),
        .rd_set   (rd_set),
        .rd_way   (rd_way),
        .rd_data  (rd_data),
        .rd_par   (rd_par),
        .rd_dup   (rd_dup),
        .pt_data  (pt_data),
        .pt_par   (pt_par)
    );

    dws_ctrl #(.DATA_W(DATA_W), .SET_W(SET_W), .WAY_W(WAY_W)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_op          (req_op),
        .req_set         (req_set),
        .req_way         (req_way),
        .req_data        (req_data),
        .sel_err         (sel_err),
        .pt_err          (pt_err),
        .rd_dup          (rd_dup),
        .rd_data         (rd_data),
        .pt_data         (pt_data),
        .rd_set          (rd_set),
        .rd_way          (rd_way),
        .wr_en           (wr_en),
        .wr_pair         (wr_pair),
        .op_set          (op_set),
        .op_way          (op_way),
        .wr_data         (wr_data),
        .dup_clr         (dup_clr),
        .dup_mark        (dup_mark),
        .fetch_req_valid (fetch_req_valid),
        .fetch_req_set   (fetch_req_set),
        .fetch_req_way   (fetch_req_way),
        .fetch_rsp_valid (fetch_rsp_valid),
        .fetch_rsp_data  (fetch_rsp_data),
        .rsp_valid       (rsp_valid),
        .rsp_status      (rsp_status),
        .rsp_data        (rsp_data)
    );

    // R1: nothing pending straight out of reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!rsp_valid && !fetch_req_valid && req_ready));
endmodule

// File: tb/test_dupway_store.sv
`timescale 1ns/1ps
module test_dupway_store;
    localparam int NSETS  = 4;
    localparam int NWAYS  = 4;
    localparam int DATA_W = 32;
    localparam int SET_W  = 2;
    localparam int WAY_W  = 2;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [SET_W-1:0]  req_set = '0;
    logic [WAY_W-1:0]  req_way = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              rsp_valid;
    logic [1:0]        rsp_status;
    logic [DATA_W-1:0] rsp_data;
    logic              fetch_req_valid;
    logic [SET_W-1:0]  fetch_req_set;
    logic [WAY_W-1:0]  fetch_req_way;
    logic              fetch_rsp_valid = 1'b0;
    logic [DATA_W-1:0] fetch_rsp_data = '0;
    logic              inj_valid = 1'b0;
    logic [SET_W-1:0]  inj_set = '0;
    logic [WAY_W-1:0]  inj_way = '0;
    logic [DATA_W-1:0] inj_mask = '0;

    dupway_store #(.NSETS(NSETS), .NWAYS(NWAYS), .DATA_W(DATA_W)) i_dupway_store (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_set(req_set), .req_way(req_way), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
        .fetch_req_valid(fetch_req_valid), .fetch_req_set(fetch_req_set),
        .fetch_req_way(fetch_req_way), .fetch_rsp_valid(fetch_rsp_valid),
        .fetch_rsp_data(fetch_rsp_data),
        .inj_valid(inj_valid), .inj_set(inj_set), .inj_way(inj_way), .inj_mask(inj_mask)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    logic [DATA_W-1:0] exp_d [$];
    logic [1:0]        exp_s [$];
    string             exp_r [$];
    logic [DATA_W-1:0] lowmem [NSETS][NWAYS];
    time               t_issue = 0;
    time               t_frsp  = 0;
    logic [SET_W-1:0]  exp_fset = '0;
    logic [WAY_W-1:0]  exp_fway = '0;
    int                fcnt = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int s, input int w,
                         input logic [DATA_W-1:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_set   = SET_W'(s);
        req_way   = WAY_W'(w);
        req_data  = d;
        t_issue   = $time;
        @(negedge clk);
        req_valid = 1'b0;
        if (op == 2'd1) begin
            check(!req_ready, "R3", "ready in mirror cycle", 64'(req_ready), 64'd0);
            @(negedge clk);
            check(req_ready, "R3", "ready after mirror", 64'(req_ready), 64'd1);
        end
    endtask

    task automatic rd(input int s, input int w, input logic [DATA_W-1:0] d,
                      input logic [1:0] st, input string req);
        exp_d.push_back(d);
        exp_s.push_back(st);
        exp_r.push_back(req);
        issue(2'd0, s, w, '0);
    endtask

    task automatic inj(input int s, input int w, input logic [DATA_W-1:0] m);
        inj_valid = 1'b1;
        inj_set   = SET_W'(s);
        inj_way   = WAY_W'(w);
        inj_mask  = m;
        @(negedge clk);
        inj_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_d.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_d.size() == 0) begin
                check(1'b0, "R4", "unexpected response", 64'(rsp_data), 64'd0);
            end else begin
                logic [DATA_W-1:0] ed;
                logic [1:0]        es;
                string             er;
                ed = exp_d.pop_front();
                es = exp_s.pop_front();
                er = exp_r.pop_front();
                check(rsp_data == ed, er, "response data", 64'(rsp_data), 64'(ed));
                check(rsp_status == es, er, "response status", 64'(rsp_status), 64'(es));
                check(rsp_status != 2'd3, "R12", "status code", 64'(rsp_status), 64'd0);
                if (es == 2'd2)
                    check($time == t_frsp + 20, "R9", "response after fetch data",
                          64'($time), 64'(t_frsp + 20));
            end
        end
    end

    // next-level memory model
    always @(negedge clk) begin
        if (!rst) begin
            if (fetch_rsp_valid) begin
                fetch_rsp_valid = 1'b0;
                fcnt = 0;
            end else if (fetch_req_valid) begin
                if (fcnt == 0)
                    check($time == t_issue + 20, "R9", "fetch request timing",
                          64'($time), 64'(t_issue + 20));
                check(fetch_req_set == exp_fset && fetch_req_way == exp_fway, "R9",
                      "fetch address", 64'({fetch_req_set, fetch_req_way}),
                      64'({exp_fset, exp_fway}));
                fcnt++;
                if (fcnt == LAT) begin
                    fetch_rsp_data  = lowmem[fetch_req_set][fetch_req_way];
                    fetch_rsp_valid = 1'b1;
                    t_frsp          = $time;
                end
            end
        end
    end

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NWAYS; w++)
                lowmem[s][w] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready, "R1", "ready after reset", 64'(req_ready), 64'd1);
        check(!rsp_valid, "R1", "no response after reset", 64'(rsp_valid), 64'd0);
        check(!fetch_req_valid, "R1", "no fetch after reset", 64'(fetch_req_valid), 64'd0);

        // R2 R4: mirrored writes, clean reads back to back
        issue(2'd1, 0, 0, 32'h1234_5678);
        rd(0, 0, 32'h1234_5678, 2'd0, "R4");
        rd(0, 1, 32'h1234_5678, 2'd0, "R2");
        issue(2'd1, 0, 3, 32'hA5C3_0F96);
        rd(0, 2, 32'hA5C3_0F96, 2'd0, "R2");
        drain();

        // R5 R6: single-bit errors in different bytes served from partner
        inj(0, 0, 32'h0000_0008);
        rd(0, 0, 32'h1234_5678, 2'd1, "R6");
        rd(0, 0, 32'h1234_5678, 2'd1, "R5");
        inj(0, 3, 32'h4000_0000);
        rd(0, 3, 32'hA5C3_0F96, 2'd1, "R5");
        drain();

        // R11: both copies bad -> refetch; R10 both ways refreshed
        inj(0, 2, 32'h0001_0100);
        lowmem[0][3] = 32'hC0FF_EE01;
        exp_fset = 2'd0;
        exp_fway = 2'd3;
        rd(0, 3, 32'hC0FF_EE01, 2'd2, "R11");
        drain();
        rd(0, 2, 32'hC0FF_EE01, 2'd0, "R10");
        rd(0, 3, 32'hC0FF_EE01, 2'd0, "R10");
        drain();
        inj(0, 2, 32'h0000_0001);
        rd(0, 2, 32'hC0FF_EE01, 2'd1, "R10");
        drain();

        // R7: fill touches one way and drops duplicate status
        issue(2'd1, 1, 2, 32'h0D0D_0D0D);
        issue(2'd2, 1, 3, 32'hEEEE_1111);
        rd(1, 3, 32'hEEEE_1111, 2'd0, "R7");
        rd(1, 2, 32'h0D0D_0D0D, 2'd0, "R7");
        drain();
        inj(1, 2, 32'h0000_0080);
        lowmem[1][2] = 32'hF00D_CAFE;
        exp_fset = 2'd1;
        exp_fway = 2'd2;
        rd(1, 2, 32'hF00D_CAFE, 2'd2, "R7");
        drain();
        rd(1, 3, 32'hF00D_CAFE, 2'd0, "R10");
        drain();

        // R8: evict drops duplicate status, data kept; R13 ignored request
        issue(2'd1, 3, 0, 32'h6B6B_0001);
        issue(2'd1, 2, 1, 32'h9999_AAAA);
        issue(2'd3, 2, 0, '0);
        rd(2, 0, 32'h9999_AAAA, 2'd0, "R8");
        drain();
        inj(2, 1, 32'h0000_0200);
        lowmem[2][1] = 32'h4848_1234;
        exp_fset = 2'd2;
        exp_fway = 2'd1;
        rd(2, 1, 32'h4848_1234, 2'd2, "R8");
        check(!req_ready, "R13", "busy during refetch", 64'(req_ready), 64'd0);
        req_valid = 1'b1;
        req_op    = 2'd1;
        req_set   = 2'd3;
        req_way   = 2'd0;
        req_data  = 32'hDEAD_0000;
        @(negedge clk);
        req_valid = 1'b0;
        drain();
        rd(3, 0, 32'h6B6B_0001, 2'd0, "R13");
        rd(3, 1, 32'h6B6B_0001, 2'd0, "R13");
        drain();

        check(exp_d.size() == 0, "R4", "responses outstanding", 64'(exp_d.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule